// File: doc/BRIEF.md
# Tiled Multiply-Accumulate Array

This block is a matrix-multiply engine built as a grid of tiles, each tile a grid of processing elements (PEs). Inside a tile the PEs pass operands to each other through wires only. Between tiles, every neighbour link passes through one pipeline register. The tile shape therefore sets the pipelining. With one PE per tile the grid is a fully systolic mesh. With a single tile holding every PE it becomes a purely combinational reduction structure. Shapes between these two are also possible.

Each PE holds an 8-bit signed weight register and a 32-bit signed accumulator. A run-time flow input selects the dataflow.

- **Weight-stationary:** weights are first shifted down into the PEs. Activations then stream in from the west edge and partial sums flow south, starting from a per-column bias on the north edge.
- **Output-stationary:** activations stream from the west and weights from the north. Each PE adds the product into its own accumulator. A drain command then shifts the accumulators south, one row per cycle, onto the result edge.

The caller skews the inputs by tile index. It also reads each result column at its own tile-column delay.

Top module: `tmac_array`

## Requirements
- R1: Every PE completes one multiply-accumulate per clock, so a new activation vector may enter every cycle. Each vector produces one full result row, one cycle apart.
- R2: While `rst` is high, the result bus, every weight register and every accumulator are cleared to zero.
- R3: On a cycle with `cmd` = 1 (load), each PE takes the weight held by the PE directly above it. The top row takes the low 8 bits of its `north_in` column. After ROWS load cycles, row r holds the weight presented on load cycle ROWS-1-r.
- R4: With `flow` = 0 (weight-stationary) and `cmd` = 0 (run), the result is computed as follows. Row r of the vector is presented on `act_in` in cycle t + r/PE_ROWS. Column c's bias is held on `north_in`. Then `result` column c, after the clock edge ending cycle t + (TILE_ROWS-1) + c/PE_COLS, equals bias[c] + sum over r of x[r]*W[r][c].
- R5: Results and timing follow R4 and R7 for any tile shape, including the fully pipelined shape (1x1 PEs per tile) and the single-tile combinational shape.
- R6: `cmd` = 3 (clear) zeroes every accumulator. With `flow` = 1 (output-stationary) and `cmd` = 0, each PE adds west activation times the low 8 bits of its north input to its accumulator. A[i][k] presented on row i in cycle k + i/PE_ROWS meets B[k][j] presented on column j in cycle k + j/PE_COLS. Accumulators do not change in weight-stationary run cycles.
- R7: On each `cmd` = 2 (drain) cycle in output-stationary flow, `result` takes the bottom-row accumulators. At the same time every accumulator takes the value of the one above it, and the top row takes zero. The d-th drain (from 0) delivers row ROWS-1-d.
- R8: In output-stationary flow, `result` keeps its value on every cycle whose command is not drain.
- R9: All accumulation wraps modulo 2^32 in two's complement.
- R10: Weight registers change only on load cycles. Clear, run and drain in either flow leave them intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flow | input | 1 | 0 = weight-stationary, 1 = output-stationary |
| cmd | input | 2 | 0 run, 1 load weights, 2 drain, 3 clear accumulators |
| act_in | input | ROWS*IN_W | West-edge activations, row r in bits [r*IN_W +: IN_W] |
| north_in | input | COLS*ACC_W | North edge: bias (weight-stationary), weight operand or load value in low IN_W bits, column c in [c*ACC_W +: ACC_W] |
| result | output | COLS*ACC_W | Registered south-edge result, column c in [c*ACC_W +: ACC_W] |

## Verification
A weight sitting in the wrong row shows up in the first weight-stationary vector after the load. Probing with unit vectors makes this visible: each one returns exactly one weight row, one tile-row latency later. A misplaced pipeline register shifts every result of a column by a cycle. The wrong vector's sum then appears where the skewed schedule expects the right one. This is seen on the first streamed vector and in every configuration whose tile shape contains that boundary. Accumulator corruption in output-stationary flow stays hidden until the drain, and then appears in the row that drains at the matching count. Weight corruption caused by a non-load command appears only in a later weight-stationary pass that skips reloading.

// File: rtl/tmac_pkg.sv
package tmac_pkg;

  typedef enum logic [1:0] {
    CMD_RUN   = 2'd0,
    CMD_LOAD  = 2'd1,
    CMD_DRAIN = 2'd2,
    CMD_CLEAR = 2'd3
  } cmd_e;

  typedef enum logic {
    FLOW_WS = 1'b0,
    FLOW_OS = 1'b1
  } flow_e;

endpackage

// File: rtl/tmac_pe.sv
module tmac_pe
  import tmac_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int ACC_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  flow_e                   flow,
  input  cmd_e                    cmd,
  input  logic signed [IN_W-1:0]  west_act,
  output logic signed [IN_W-1:0]  east_act,
  input  logic signed [ACC_W-1:0] north_data,
  output logic signed [ACC_W-1:0] south_data,
  input  logic signed [IN_W-1:0]  w_north,
  output logic signed [IN_W-1:0]  w_south,
  input  logic signed [ACC_W-1:0] acc_north,
  output logic signed [ACC_W-1:0] acc_south
);

  logic signed [IN_W-1:0]  w_q;
  logic signed [ACC_W-1:0] acc_q;
  logic signed [IN_W-1:0]  b_op;
  logic signed [ACC_W-1:0] prod_ws;
  logic signed [ACC_W-1:0] prod_os;

  // Operands widened before the multiply so products are exact
  assign b_op    = $signed(north_data[IN_W-1:0]);
  assign prod_ws = ACC_W'(west_act) * ACC_W'(w_q);
  assign prod_os = ACC_W'(west_act) * ACC_W'(b_op);

  always_comb begin
    east_act   = west_act;
    south_data = (flow == FLOW_WS) ? north_data + prod_ws : north_data;
  end

  assign w_south   = w_q;
  assign acc_south = acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      w_q   <= '0;
      acc_q <= '0;
    end else begin
      if (cmd == CMD_LOAD) w_q <= w_north;
      case (cmd)
        CMD_CLEAR: acc_q <= '0;
        CMD_DRAIN: acc_q <= acc_north;
        CMD_RUN:   if (flow == FLOW_OS) acc_q <= acc_q + prod_os;
        default:   acc_q <= acc_q;
      endcase
    end
  end

  assert_weight_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd != CMD_LOAD) |=> $stable(w_q));

  assert_acc_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_CLEAR) |=> (acc_q == '0));

  assert_ws_acc_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (flow == FLOW_WS && cmd == CMD_RUN) |=> $stable(acc_q));

endmodule

// File: rtl/tmac_tile.sv
module tmac_tile
  import tmac_pkg::*;
#(
  parameter int PE_ROWS = 2,
  parameter int PE_COLS = 2,
  parameter int IN_W    = 8,
  parameter int ACC_W   = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  flow_e                      flow,
  input  cmd_e                       cmd,
  input  logic [PE_ROWS*IN_W-1:0]    west_act,
  output logic [PE_ROWS*IN_W-1:0]    east_act,
  input  logic [PE_COLS*ACC_W-1:0]   north_data,
  output logic [PE_COLS*ACC_W-1:0]   south_data,
  input  logic [PE_COLS*IN_W-1:0]    w_north,
  output logic [PE_COLS*IN_W-1:0]    w_south,
  input  logic [PE_COLS*ACC_W-1:0]   acc_north,
  output logic [PE_COLS*ACC_W-1:0]   acc_south
);

  // Links between PEs: plain wires, no registers inside a tile
  logic signed [IN_W-1:0]  h_link [PE_ROWS][PE_COLS+1];
  logic signed [ACC_W-1:0] v_link [PE_ROWS+1][PE_COLS];
  logic signed [IN_W-1:0]  w_link [PE_ROWS+1][PE_COLS];
  logic signed [ACC_W-1:0] a_link [PE_ROWS+1][PE_COLS];

  for (genvar r = 0; r < PE_ROWS; r++) begin : g_row_edge
    assign h_link[r][0]              = west_act[r*IN_W +: IN_W];
    assign east_act[r*IN_W +: IN_W]  = h_link[r][PE_COLS];
  end

  for (genvar c = 0; c < PE_COLS; c++) begin : g_col_edge
    assign v_link[0][c]                  = north_data[c*ACC_W +: ACC_W];
    assign south_data[c*ACC_W +: ACC_W]  = v_link[PE_ROWS][c];
    assign w_link[0][c]                  = w_north[c*IN_W +: IN_W];
    assign w_south[c*IN_W +: IN_W]       = w_link[PE_ROWS][c];
    assign a_link[0][c]                  = acc_north[c*ACC_W +: ACC_W];
    assign acc_south[c*ACC_W +: ACC_W]   = a_link[PE_ROWS][c];
  end

  for (genvar r = 0; r < PE_ROWS; r++) begin : g_pr
    for (genvar c = 0; c < PE_COLS; c++) begin : g_pc
      tmac_pe #(.IN_W(IN_W), .ACC_W(ACC_W)) u_pe (
        .clk        (clk),
        .rst        (rst),
        .flow       (flow),
        .cmd        (cmd),
        .west_act   (h_link[r][c]),
        .east_act   (h_link[r][c+1]),
        .north_data (v_link[r][c]),
        .south_data (v_link[r+1][c]),
        .w_north    (w_link[r][c]),
        .w_south    (w_link[r+1][c]),
        .acc_north  (a_link[r][c]),
        .acc_south  (a_link[r+1][c])
      );
    end
  end

endmodule

// File: rtl/tmac_array.sv
module tmac_array
  import tmac_pkg::*;
#(
  parameter int TILE_ROWS = 2,
  parameter int TILE_COLS = 2,
  parameter int PE_ROWS   = 2,
  parameter int PE_COLS   = 2,
  parameter int IN_W      = 8,
  parameter int ACC_W     = 32
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   flow,
  input  logic [1:0]                             cmd,
  input  logic [TILE_ROWS*PE_ROWS*IN_W-1:0]      act_in,
  input  logic [TILE_COLS*PE_COLS*ACC_W-1:0]     north_in,
  output logic [TILE_COLS*PE_COLS*ACC_W-1:0]     result
);

  localparam int ROWS    = TILE_ROWS * PE_ROWS;
  localparam int COLS    = TILE_COLS * PE_COLS;
  localparam int ACT_BUS = PE_ROWS * IN_W;
  localparam int DAT_BUS = PE_COLS * ACC_W;
  localparam int WGT_BUS = PE_COLS * IN_W;

  flow_e flow_q;
  cmd_e  cmd_q;
  assign flow_q = flow_e'(flow);
  assign cmd_q  = cmd_e'(cmd);

  logic [ACT_BUS-1:0] act_to   [TILE_ROWS][TILE_COLS];
  logic [ACT_BUS-1:0] act_from [TILE_ROWS][TILE_COLS];
  logic [DAT_BUS-1:0] dat_to   [TILE_ROWS][TILE_COLS];
  logic [DAT_BUS-1:0] dat_from [TILE_ROWS][TILE_COLS];
  logic [WGT_BUS-1:0] w_to     [TILE_ROWS][TILE_COLS];
  logic [WGT_BUS-1:0] w_from   [TILE_ROWS][TILE_COLS];
  logic [DAT_BUS-1:0] acc_to   [TILE_ROWS][TILE_COLS];
  logic [DAT_BUS-1:0] acc_from [TILE_ROWS][TILE_COLS];

  logic [COLS*ACC_W-1:0] bottom_dat;
  logic [COLS*ACC_W-1:0] bottom_acc;

  for (genvar tr = 0; tr < TILE_ROWS; tr++) begin : g_tr
    for (genvar tc = 0; tc < TILE_COLS; tc++) begin : g_tc

      tmac_tile #(
        .PE_ROWS (PE_ROWS),
        .PE_COLS (PE_COLS),
        .IN_W    (IN_W),
        .ACC_W   (ACC_W)
      ) u_tile (
        .clk        (clk),
        .rst        (rst),
        .flow       (flow_q),
        .cmd        (cmd_q),
        .west_act   (act_to[tr][tc]),
        .east_act   (act_from[tr][tc]),
        .north_data (dat_to[tr][tc]),
        .south_data (dat_from[tr][tc]),
        .w_north    (w_to[tr][tc]),
        .w_south    (w_from[tr][tc]),
        .acc_north  (acc_to[tr][tc]),
        .acc_south  (acc_from[tr][tc])
      );

      // Horizontal link: array edge or one pipeline register
      if (tc == 0) begin : g_west_edge
        assign act_to[tr][tc] = act_in[tr*ACT_BUS +: ACT_BUS];
      end else begin : g_west_pipe
        always_ff @(posedge clk) begin
          if (rst) act_to[tr][tc] <= '0;
          else     act_to[tr][tc] <= act_from[tr][tc-1];
        end
      end

      // Vertical link: array edge or one pipeline register on the data bus;
      // weight and accumulator chains are already registered in the PEs
      if (tr == 0) begin : g_north_edge
        assign dat_to[tr][tc] = north_in[tc*DAT_BUS +: DAT_BUS];
        assign acc_to[tr][tc] = '0;
        for (genvar pc = 0; pc < PE_COLS; pc++) begin : g_wsl
          assign w_to[tr][tc][pc*IN_W +: IN_W] =
            north_in[(tc*PE_COLS+pc)*ACC_W +: IN_W];
        end
      end else begin : g_north_pipe
        always_ff @(posedge clk) begin
          if (rst) dat_to[tr][tc] <= '0;
          else     dat_to[tr][tc] <= dat_from[tr-1][tc];
        end
        assign w_to[tr][tc]   = w_from[tr-1][tc];
        assign acc_to[tr][tc] = acc_from[tr-1][tc];
      end

      if (tr == TILE_ROWS-1) begin : g_south_edge
        assign bottom_dat[tc*DAT_BUS +: DAT_BUS] = dat_from[tr][tc];
        assign bottom_acc[tc*DAT_BUS +: DAT_BUS] = acc_from[tr][tc];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                      result <= '0;
    else if (flow_q == FLOW_WS)   result <= bottom_dat;
    else if (cmd_q == CMD_DRAIN)  result <= bottom_acc;
  end

  assert_reset_clear_R2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (result == '0));

  assert_os_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (flow_q == FLOW_OS && cmd_q != CMD_DRAIN) |=> $stable(result));

  initial begin
    assert_geometry_R5: assert (ROWS >= 1 && COLS >= 1 && ACC_W >= 2*IN_W);
  end

endmodule

// File: tb/tmac_array_bench.sv
`timescale 1ns/1ps
module tmac_array_bench;

  localparam int NCFG = 3;
  localparam int N    = 4;
  localparam int IW   = 8;
  localparam int AW   = 32;
  localparam int V    = 4;
  localparam int K    = 3;
  localparam int TRS [NCFG] = '{2, 4, 1};
  localparam int TCS [NCFG] = '{2, 4, 1};
  localparam int PRS [NCFG] = '{2, 1, 4};
  localparam int PCS [NCFG] = '{2, 1, 4};

  logic clk = 1'b0;
  logic rst;
  logic [N*IW-1:0] act_b  [NCFG];
  logic [N*AW-1:0] nor_b  [NCFG];
  logic [N*AW-1:0] res_b  [NCFG];
  logic            flow_b [NCFG];
  logic [1:0]      cmd_b  [NCFG];

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic signed [IW-1:0] wm [N][N];
  logic signed [IW-1:0] x1 [V][N];
  logic signed [IW-1:0] x2 [V][N];
  logic signed [IW-1:0] am [N][K];
  logic signed [IW-1:0] bm [K][N];
  logic signed [AW-1:0] bias1 [N];
  logic signed [AW-1:0] bias2 [N];

  always #4 clk = ~clk;

  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    tmac_array #(
      .TILE_ROWS (TRS[g]),
      .TILE_COLS (TCS[g]),
      .PE_ROWS   (PRS[g]),
      .PE_COLS   (PCS[g]),
      .IN_W      (IW),
      .ACC_W     (AW)
    ) u_tmac_array (
      .clk      (clk),
      .rst      (rst),
      .flow     (flow_b[g]),
      .cmd      (cmd_b[g]),
      .act_in   (act_b[g]),
      .north_in (nor_b[g]),
      .result   (res_b[g])
    );
  end

  task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, $signed(act), $signed(exp));
    end
  endtask

  task automatic idle(input int g);
    act_b[g] = '0;
    nor_b[g] = '0;
    cmd_b[g] = 2'd0;
  endtask

  // Weight-stationary pass; second pass reuses weights without a load
  task automatic ws_test(input int g, input bit second);
    logic signed [AW-1:0] y [V][N];
    string tag;
    for (int v = 0; v < V; v++)
      for (int c = 0; c < N; c++) begin
        y[v][c] = second ? bias2[c] : bias1[c];
        for (int r = 0; r < N; r++)
          y[v][c] = y[v][c] + AW'(second ? x2[v][r] : x1[v][r]) * AW'(wm[r][c]);
      end
    flow_b[g] = 1'b0;
    if (!second) begin
      for (int k = 0; k < N; k++) begin
        @(negedge clk);
        cmd_b[g] = 2'd1;
        for (int c = 0; c < N; c++) nor_b[g][c*AW +: AW] = AW'(wm[N-1-k][c]);
      end
    end
    for (int s = 0; s <= V + TRS[g] + TCS[g] - 1; s++) begin
      @(negedge clk);
      for (int c = 0; c < N; c++) begin
        int v;
        v = s - 1 - (TRS[g] - 1) - c / PCS[g];
        if (v >= 0 && v < V) begin
          if (second)      tag = (v == 0) ? "R9" : "R10";
          else if (v < 2)  tag = "R3";
          else if (v == 2) tag = "R1";
          else             tag = (g == 0) ? "R4" : "R5";
          check($sformatf("%s cfg%0d ws vec%0d col%0d", tag, g, v, c),
                res_b[g][c*AW +: AW], y[v][c]);
        end
      end
      cmd_b[g] = 2'd0;
      for (int c = 0; c < N; c++) nor_b[g][c*AW +: AW] = second ? bias2[c] : bias1[c];
      for (int r = 0; r < N; r++) begin
        int v;
        v = s - r / PRS[g];
        act_b[g][r*IW +: IW] = (v >= 0 && v < V) ? (second ? x2[v][r] : x1[v][r]) : '0;
      end
    end
    idle(g);
  endtask

  // Output-stationary pass: clear, stream A and B, then drain
  task automatic os_test(input int g);
    logic signed [AW-1:0] cm [N][N];
    logic [N*AW-1:0] held;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        cm[i][j] = '0;
        for (int k = 0; k < K; k++) cm[i][j] = cm[i][j] + AW'(am[i][k]) * AW'(bm[k][j]);
      end
    held = '0;
    for (int s = 0; s < TRS[g] + TCS[g]; s++) begin
      @(negedge clk);
      if (s == 1) held = res_b[g];
      flow_b[g] = 1'b1;
      cmd_b[g]  = 2'd3;
      act_b[g]  = '0;
      nor_b[g]  = '0;
    end
    for (int s = 0; s < K + TRS[g] + TCS[g] - 2; s++) begin
      @(negedge clk);
      cmd_b[g] = 2'd0;
      for (int i = 0; i < N; i++) begin
        int k;
        k = s - i / PRS[g];
        act_b[g][i*IW +: IW] = (k >= 0 && k < K) ? am[i][k] : '0;
      end
      for (int j = 0; j < N; j++) begin
        int k;
        k = s - j / PCS[g];
        nor_b[g][j*AW +: AW] = (k >= 0 && k < K) ? AW'(bm[k][j]) : '0;
      end
    end
    @(negedge clk);
    for (int c = 0; c < N; c++)
      check($sformatf("R8 cfg%0d os hold col%0d", g, c), res_b[g][c*AW +: AW], held[c*AW +: AW]);
    act_b[g] = '0;
    nor_b[g] = '0;
    for (int d = 0; d < N; d++) begin
      cmd_b[g] = 2'd2;
      @(negedge clk);
      for (int c = 0; c < N; c++)
        check($sformatf("%s cfg%0d os drain%0d col%0d", (d == 0) ? "R6" : "R7", g, d, c),
              res_b[g][c*AW +: AW], cm[N-1-d][c]);
    end
    idle(g);
  endtask

  initial begin
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) wm[r][c] = IW'((r*4 + c)*9 - 70);
    for (int v = 0; v < V; v++)
      for (int r = 0; r < N; r++) begin
        x1[v][r] = '0;
        x2[v][r] = IW'(127 - 40*v);
      end
    x1[0][0] = 8'sd1;
    x1[1][3] = 8'sd1;
    x1[2][0] = 8'sd3;  x1[2][1] = -8'sd7;  x1[2][2] = 8'sd11; x1[2][3] = -8'sd2;
    x1[3][0] = -8'sd128; x1[3][1] = 8'sd127; x1[3][2] = -8'sd1; x1[3][3] = 8'sd5;
    for (int c = 0; c < N; c++) begin
      bias1[c] = AW'(100*c - 150);
      bias2[c] = 32'sh7FFF_FF00;
    end
    for (int i = 0; i < N; i++)
      for (int k = 0; k < K; k++) am[i][k] = IW'(i*3 - k*5 + 2);
    for (int k = 0; k < K; k++)
      for (int j = 0; j < N; j++) bm[k][j] = IW'(7*j - 4*k - 10);
    am[3][2] = -8'sd128;
    bm[2][3] = -8'sd128;

    rst = 1'b1;
    for (int g = 0; g < NCFG; g++) begin
      idle(g);
      flow_b[g] = 1'b0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int g = 0; g < NCFG; g++)
      for (int c = 0; c < N; c++)
        check($sformatf("R2 cfg%0d reset col%0d", g, c), res_b[g][c*AW +: AW], '0);
    rst = 1'b0;

    for (int g = 0; g < NCFG; g++) begin
      ws_test(g, 1'b0);
      os_test(g);
      ws_test(g, 1'b1);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule